// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a hardware watchdog for a small processor subsystem. It stays off after a system reset and is switched on only when software writes a two-byte key to its key register: 0x1E and then 0xE1. Software repeats the same two writes to restart the count. Once the watchdog runs, no write can stop it. Only the reset that the watchdog itself produces, or a system reset, turns it off.

The count advances on a machine-cycle tick input. A prescaler divides the tick by 2^S, and a 14-bit base counter counts the prescaler wraps. A 3-bit period code S therefore sets the timeout to (2^14 − 1)·2^S ticks. The period code is written to a separate register and takes effect only when the next key sequence completes. When the timeout expires, the block raises a reset request for a fixed number of clock periods. During that time the block clears itself completely.

An idle-hold input lets the system freeze the count while the processor idles.

Top module: `keyed_watchdog`

## Requirements
- R1: After `rst_n` is released, the watchdog is disabled and `wdt_reset` stays low however many ticks arrive, as long as no key sequence is written.
- R2: A write of 0x1E to the key register (address 0) followed later by a write of 0xE1 to the key register enables the watchdog. With period code 0, `wdt_reset` rises on the clock edge that samples the 16383rd counted tick after the edge that took the 0xE1 write.
- R3: Repeating the 0x1E / 0xE1 sequence while the watchdog runs restarts the count from zero, so the expiry moves to 16383·2^S counted ticks after the new 0xE1 write.
- R4: A key-register write that is not the expected next byte aborts the sequence. 0xE1 that does not directly follow 0x1E in the key register has no effect. 0x1E always starts a new sequence.
- R5: No write to the key register stops a running watchdog or delays its expiry, unless it completes the key sequence.
- R6: The period code sits in bits [2:0] of the period register (address 1). It is captured when a key sequence completes and sets the timeout to (2^14 − 1)·2^S counted ticks. Writing the code during a count does not change that count.
- R7: On expiry, `wdt_reset` is held high for exactly 96 clock cycles and then returns low.
- R8: The expiry clears the enable and the stored period code. After the pulse, no further reset occurs without a new key sequence, and a new sequence uses period code 0 unless the code is rewritten.
- R9: A tick is not counted while both `idle` and `idle_hold` are high. Either input alone has no effect on the count.
- R10: The count advances only on clock edges where `cycle_tick` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low system reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 key register, 1 period register |
| wr_data | input | 8 | Write data |
| cycle_tick | input | 1 | One-clock pulse per machine cycle |
| idle | input | 1 | Processor is in idle mode |
| idle_hold | input | 1 | Freeze the count while `idle` is high |
| wdt_reset | output | 1 | Reset request, high for 96 clocks on expiry |

## Verification
The only observable output is the reset request. A wrong prescaler, base count or gating state therefore shows up as a rising edge of `wdt_reset` that moves away from the predicted cycle. Each expiry is checked on its exact edge and on the cycle before it, so an error of even one tick is caught at the first expiry, 16383·2^S ticks after the last service. A sequence decoder left armed or disarmed, a stale period code, or an enable that survives the pulse shows up at the next expiry instead: one arrives early, late or not at all, and a spurious pulse appears one full period after the previous one.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_e;
endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
    import wdt_pkg::*;
#(
    parameter int ADDR_W     = 2,
    parameter int DATA_W     = 8,
    parameter int SEL_W      = 3,
    parameter int KEY_ADDR   = 0,
    parameter int SEL_ADDR   = 1,
    parameter int KEY_FIRST  = 'h1E,
    parameter int KEY_SECOND = 'hE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              service,
    output logic [SEL_W-1:0]  sel_pend
);
    typedef struct packed {
        seq_e             seq;
        logic [SEL_W-1:0] sel;
    } key_state_t;

    key_state_t st_d, st_q;
    logic       key_hit, sel_hit;

    always_comb begin
        st_d    = st_q;
        service = 1'b0;
        key_hit = wr_en && (wr_addr == ADDR_W'(KEY_ADDR));
        sel_hit = wr_en && (wr_addr == ADDR_W'(SEL_ADDR));
        if (hold) begin
            // The pulse is a reset of the whole block: writes are dropped.
            st_d = '0;
        end else begin
            if (sel_hit) st_d.sel = wr_data[SEL_W-1:0];
            if (key_hit) begin
                if (wr_data == DATA_W'(KEY_FIRST)) begin
                    st_d.seq = SEQ_ARMED;
                end else begin
                    st_d.seq = SEQ_IDLE;
                    if (st_q.seq == SEQ_ARMED && wr_data == DATA_W'(KEY_SECOND))
                        service = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_pend = st_q.sel;
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int BASE_W = 14,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              service,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic              step,
    output logic              expire,
    output logic              en_q,
    output logic [BASE_W-1:0] base_q
);
    localparam int PRE_W = (2 ** SEL_W) - 1;

    typedef struct packed {
        logic              en;
        logic [SEL_W-1:0]  sel;
        logic [PRE_W-1:0]  pre;
        logic [BASE_W-1:0] base;
    } cnt_state_t;

    cnt_state_t        st_d, st_q;
    logic [PRE_W-1:0]  pre_lim;
    logic              pre_wrap, base_last;

    always_comb begin
        st_d      = st_q;
        pre_lim   = ~({PRE_W{1'b1}} << st_q.sel);
        pre_wrap  = (st_q.pre == pre_lim);
        base_last = (st_q.base == {{(BASE_W-1){1'b1}}, 1'b0});
        expire    = st_q.en && step && pre_wrap && base_last && !hold;
        if (hold || expire) begin
            st_d = '0;
        end else if (service) begin
            st_d.en   = 1'b1;
            st_d.sel  = sel_in;
            st_d.pre  = '0;
            st_d.base = '0;
        end else if (st_q.en && step) begin
            if (pre_wrap) begin
                st_d.pre  = '0;
                st_d.base = st_q.base + BASE_W'(1);
            end else begin
                st_d.pre  = st_q.pre + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q   = st_q.en;
    assign base_q = st_q.base;
endmodule

// File: rtl/wdt_stretch.sv
module wdt_stretch #(
    parameter int PULSE_LEN = 96
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic active
);
    localparam int CNT_W = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } str_state_t;

    str_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire)                st_d.cnt = CNT_W'(PULSE_LEN);
        else if (st_q.cnt != '0) st_d.cnt = st_q.cnt - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = (st_q.cnt != '0);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
    parameter int ADDR_W     = 2,
    parameter int DATA_W     = 8,
    parameter int BASE_W     = 14,
    parameter int SEL_W      = 3,
    parameter int PULSE_LEN  = 96,
    parameter int KEY_ADDR   = 0,
    parameter int SEL_ADDR   = 1,
    parameter int KEY_FIRST  = 'h1E,
    parameter int KEY_SECOND = 'hE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cycle_tick,
    input  logic              idle,
    input  logic              idle_hold,
    output logic              wdt_reset
);
    logic              service, expire, pulse_on, step, en_q;
    logic [SEL_W-1:0]  sel_pend;
    logic [BASE_W-1:0] base_q;

    assign step = cycle_tick && !(idle && idle_hold);

    wdt_key_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
        .KEY_ADDR(KEY_ADDR), .SEL_ADDR(SEL_ADDR),
        .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
    ) u_key (
        .clk(clk), .rst_n(rst_n), .hold(pulse_on),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .service(service), .sel_pend(sel_pend)
    );

    wdt_count #(.BASE_W(BASE_W), .SEL_W(SEL_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .hold(pulse_on), .service(service),
        .sel_in(sel_pend), .step(step), .expire(expire),
        .en_q(en_q), .base_q(base_q)
    );

    wdt_stretch #(.PULSE_LEN(PULSE_LEN)) u_str (
        .clk(clk), .rst_n(rst_n), .fire(expire), .active(pulse_on)
    );

    assign wdt_reset = pulse_on;
endmodule

// File: rtl/keyed_watchdog_sva.sv
module keyed_watchdog_sva #(
    parameter int ADDR_W     = 2,
    parameter int DATA_W     = 8,
    parameter int BASE_W     = 14,
    parameter int PULSE_LEN  = 96,
    parameter int KEY_ADDR   = 0,
    parameter int KEY_SECOND = 'hE1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              idle,
    input logic              idle_hold,
    input logic              wdt_reset,
    input logic              en_q,
    input logic [BASE_W-1:0] base_q
);
    logic [31:0] run_q;
    logic        key_wr;

    assign key_wr = wr_en && (wr_addr == ADDR_W'(KEY_ADDR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_q <= '0;
        else if (wdt_reset) run_q <= run_q + 32'd1;
        else                run_q <= '0;
    end

    // R1 / R2: a pulse only starts from a running watchdog
    assert_pulse_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_reset) |-> $past(en_q));

    // R2: enable rises only on the closing key byte
    assert_enable_by_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> $past(key_wr && wr_data == DATA_W'(KEY_SECOND)));

    // R5: software cannot clear the enable
    assert_enable_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !wdt_reset) |=> (en_q || wdt_reset));

    // R7: pulse width
    assert_pulse_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_reset) |-> (run_q == 32'(PULSE_LEN)));

    // R8: enable is gone when the pulse ends
    assert_clear_after_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_reset) |-> !en_q);

    // R9: base count frozen while idle is held
    assert_idle_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !wdt_reset && idle && idle_hold && !key_wr) |=> $stable(base_q));
endmodule

bind keyed_watchdog keyed_watchdog_sva #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_W(BASE_W), .PULSE_LEN(PULSE_LEN),
    .KEY_ADDR(KEY_ADDR), .KEY_SECOND(KEY_SECOND)
) u_sva (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .idle(idle), .idle_hold(idle_hold), .wdt_reset(wdt_reset),
    .en_q(en_q), .base_q(base_q)
);

// File: tb/keyed_watchdog_bench.sv
`timescale 1ns/1ps
module keyed_watchdog_bench;
    localparam int P0 = 16383;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       cycle_tick = 1'b1;
    logic       idle = 1'b0;
    logic       idle_hold = 1'b0;
    logic       wdt_reset;

    int  cyc = 0;
    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 1'b0;

    typedef struct {
        int    at;
        logic  val;
        string tag;
    } exp_t;
    exp_t sb[$];
    exp_t mon_e;

    keyed_watchdog u_keyed_watchdog (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cycle_tick(cycle_tick), .idle(idle),
        .idle_hold(idle_hold), .wdt_reset(wdt_reset)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare scheduled expectations at the cycle they name
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            mon_e = sb.pop_front();
            vectors++;
            if (mon_e.at < cyc) begin
                miscompares++;
                $display("FAIL %s: check for cycle %0d missed (now %0d)", mon_e.tag, mon_e.at, cyc);
            end else if (wdt_reset !== mon_e.val) begin
                miscompares++;
                $display("FAIL %s: cycle %0d wdt_reset actual %b expected %b",
                         mon_e.tag, cyc, wdt_reset, mon_e.val);
            end
        end
    end

    task automatic expect_at(input int at, input logic v, input string tag);
        exp_t e;
        e.at = at; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic expect_expiry(input int e0, input int period, input string tag);
        expect_at(e0 + period - 1,  1'b0, tag);
        expect_at(e0 + period,      1'b1, tag);
        expect_at(e0 + period + 95, 1'b1, {tag, " R7"});
        expect_at(e0 + period + 96, 1'b0, {tag, " R7"});
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d, output int at);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        at = cyc;
        wr_en = 1'b0;
    endtask

    task automatic service(output int at);
        int t;
        write_reg(2'd0, 8'h1E, t);
        write_reg(2'd0, 8'hE1, at);
    endtask

    task automatic drain;
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    task automatic hold_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int e0, e1, t;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: disabled after reset
        expect_at(cyc + 1, 1'b0, "R1");
        expect_at(cyc + 16400, 1'b0, "R1");
        drain();

        // R2, R7: enable and expire with period code 0
        service(e0);
        expect_expiry(e0, P0, "R2");
        drain();
        // R8: no second pulse after expiry
        expect_at(cyc + 16500, 1'b0, "R8");
        drain();

        // R3: service restarts the count
        service(e0);
        while (cyc < e0 + 10000) @(negedge clk);
        service(e1);
        expect_at(e0 + P0, 1'b0, "R3");
        expect_expiry(e1, P0, "R3");
        drain();

        // R4, R5, R6: broken sequences, stray writes, mid-count period change
        service(e0);
        write_reg(2'd1, 8'h01, t);   // R6 pending only
        write_reg(2'd0, 8'h1E, t);   // R4 arm
        write_reg(2'd0, 8'h55, t);   // R4 abort
        write_reg(2'd0, 8'hE1, t);   // R4 no effect
        write_reg(2'd0, 8'h00, t);   // R5 no stop
        write_reg(2'd0, 8'hE1, t);   // R4 lone second byte
        expect_expiry(e0, P0, "R4 R5 R6");
        drain();

        // R8 (period code cleared), R9, R10: tick gating
        service(e0);
        hold_cycles(50);
        idle = 1'b1;        hold_cycles(200);   // idle alone: counts
        idle = 1'b0; idle_hold = 1'b1; hold_cycles(100); // hold alone: counts
        idle = 1'b1;        hold_cycles(500);   // both: frozen
        idle = 1'b0; idle_hold = 1'b0;
        cycle_tick = 1'b0;  hold_cycles(300);   // no ticks
        cycle_tick = 1'b1;
        expect_expiry(e0, P0 + 800, "R8 R9 R10");
        drain();

        // R6: period code 1 doubles the timeout
        write_reg(2'd1, 8'h01, t);
        service(e0);
        expect_expiry(e0, 2 * P0, "R6");
        drain();

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: run hung at cycle %0d, actual pending %0d expected 0", cyc, sb.size());
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule